// File: doc/BRIEF.md
# Dual-Port Paddle Potentiometer Scanner

This block measures four analog paddle lines: the X and Y lines on each of two joystick ports. It first holds every line discharged. It then releases the lines and counts the ticks each line needs to charge through its external resistance until its comparator reports a threshold crossing. The count is the measured value. All four lines are measured in the same scan, and scans repeat without a pause. A programmable divider of the system clock sets the tick, so software can shorten a full scan.

Results are read through a small register bus:

- Four dedicated byte registers always hold the last complete value of each line.
- A legacy X/Y register pair shows the port chosen by a select field in a control register.
- In live mode, the legacy pair follows the dedicated values of the selected port at once.
- In timed mode, the legacy pair holds a snapshot that is refreshed every 512 ticks of a 1 MHz time base. A port change restarts that window, which reproduces the wait of the older scheme.
- An optional button view packs one "pressed" bit per line into a single register, for three-button pads.

The scan sequencer has two states:

- DISCHARGE moves to CHARGE after its 256th tick.
- CHARGE moves to DISCHARGE after its 256th tick, which ends the scan.

The legacy view has two states:

- LIVE moves to WAIT when timed mode is enabled.
- WAIT stays in WAIT, restarting its window on each select write, and returns to LIVE when timed mode is cleared.

Top module: `paddle_scan`

## Requirements
- R1: After reset, each dedicated register (0x4..0x7) and each legacy register (0x1, 0x2) reads 0xFF. The button register (0x8), the mode register (0x3), the divider register (0x9) and the control register (0x0) read 0. All four discharge outputs are high.
- R2: A scan drives the discharge outputs high for 256 ticks and then low for 256 ticks. With divider value 0 a tick is every clock, so a scan lasts 512 clocks, of which 256 have the outputs low.
- R3: A line's result is the number of charge-phase ticks on which its comparator was sampled low before it first read high. The result saturates at 255.
- R4: The dedicated registers are ordered port 1 X at 0x4, port 1 Y at 0x5, port 2 X at 0x6 and port 2 Y at 0x7.
- R5: A dedicated register changes only at the clock edge that ends a scan. A read taken mid-scan returns the previous complete value.
- R6: The divider register at 0x9 makes a tick every (value+1) clocks, so a scan lasts 512*(value+1) clocks.
- R7: Bits [7:6] of the control register at 0x0 select the legacy port: 2'b10 selects port 2, and any other value selects port 1. With mode bit 0 clear, 0x1 reads the selected port's X result and 0x2 its Y result, starting in the cycle after the select write.
- R8: With mode bit 0 set, 0x1 and 0x2 hold a snapshot. The snapshot is taken when the mode is entered, and then every 512 ticks of a 1 MHz time base (25 600 clocks at 50 MHz). A select write restarts that window and leaves the old snapshot visible until the window ends.
- R9: With mode bit 1 set, 0x8 bits [0..3] are set for port 1 X, port 1 Y, port 2 X and port 2 Y when that result is below 128. With mode bit 1 clear, 0x8 reads 0.
- R10: The control, mode (bits [1:0]) and divider registers read back as written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 4 | Register address |
| bus_wr_i | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| cmp_i | input | 4 | Per-line comparator: high once the line crossed its threshold (P1X, P1Y, P2X, P2Y) |
| dump_o | output | 4 | Per-line discharge enable (P1X, P1Y, P2X, P2Y) |

## Verification
Dedicated results and button bits change at the edge that ends a scan, which is the edge where discharge rises again. The bench therefore waits for that rise seen at a falling edge and reads afterwards. It lets one mixed scan pass after each stimulus change and compares a mid-charge read with the read taken at the scan boundary. Reads are combinational, so a write is visible at the falling edge after its rising edge. The exception is the timed legacy pair, which is due exactly 25 600 edges after the select write. The bench samples it 14 edges before and 7 edges after that point.

// File: rtl/pot_pkg.sv
package pot_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 4;

    typedef enum logic {
        SCN_DUMP,
        SCN_CHARGE
    } scan_state_t;

    typedef enum logic {
        LEG_LIVE,
        LEG_WAIT
    } leg_state_t;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] A_LEG_X = 4'h1;
    localparam logic [ADDR_W-1:0] A_LEG_Y = 4'h2;
    localparam logic [ADDR_W-1:0] A_MODE  = 4'h3;
    localparam logic [ADDR_W-1:0] A_P1X   = 4'h4;
    localparam logic [ADDR_W-1:0] A_P1Y   = 4'h5;
    localparam logic [ADDR_W-1:0] A_P2X   = 4'h6;
    localparam logic [ADDR_W-1:0] A_P2Y   = 4'h7;
    localparam logic [ADDR_W-1:0] A_BTN   = 4'h8;
    localparam logic [ADDR_W-1:0] A_DIV   = 4'h9;
endpackage

// File: rtl/pot_scan_seq.sv
module pot_scan_seq
    import pot_pkg::*;
#(
    parameter int unsigned PHASE = 256,
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o,
    output logic             charge_start_o,
    output logic             charging_o,
    output logic             scan_done_o,
    output logic             dump_o
);
    localparam int unsigned PH_W = (PHASE > 1) ? $clog2(PHASE) : 1;

    scan_state_t      st_q, st_d;
    logic [DIV_W-1:0] pre_q;
    logic [PH_W-1:0]  ph_q;
    logic             ph_last;

    assign tick_o  = (pre_q >= div_i);
    assign ph_last = (ph_q == PH_W'(PHASE - 1));

    // tick prescaler
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pre_q <= '0;
        else if (tick_o) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end

    // phase tick counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     ph_q <= '0;
        else if (tick_o) ph_q <= ph_last ? '0 : ph_q + 1'b1;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SCN_DUMP:   if (tick_o && ph_last) st_d = SCN_CHARGE;
            SCN_CHARGE: if (tick_o && ph_last) st_d = SCN_DUMP;
            default:    st_d = SCN_DUMP;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= SCN_DUMP;
        else         st_q <= st_d;
    end

    always_comb begin
        dump_o         = (st_q == SCN_DUMP);
        charging_o     = (st_q == SCN_CHARGE);
        charge_start_o = (st_q == SCN_DUMP) && tick_o && ph_last;
        scan_done_o    = (st_q == SCN_CHARGE) && tick_o && ph_last;
    end

    // R2: discharge only resumes right after a completed charge phase
    a_r2_dump_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dump_o) |-> $past(scan_done_o));
    // R2: charge phase only begins after a discharge phase end
    a_r2_charge_after_dump: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(charging_o) |-> $past(charge_start_o));
endmodule

// File: rtl/pot_line_meas.sv
module pot_line_meas #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             charge_start_i,
    input  logic             charging_i,
    input  logic             scan_done_i,
    input  logic             cmp_i,
    output logic [CNT_W-1:0] res_o
);
    logic [CNT_W-1:0] cnt_q, cnt_d, res_q;
    logic             trip_q, trip_d;

    always_comb begin
        cnt_d  = cnt_q;
        trip_d = trip_q;
        if (charge_start_i) begin
            cnt_d  = '0;
            trip_d = 1'b0;
        end else if (charging_i && tick_i && !trip_q) begin
            if (cmp_i)              trip_d = 1'b1;
            else if (cnt_q != '1)   cnt_d  = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            trip_q <= 1'b0;
            res_q  <= '1;
        end else begin
            cnt_q  <= cnt_d;
            trip_q <= trip_d;
            if (scan_done_i) res_q <= cnt_d;
        end
    end

    assign res_o = res_q;

    // R5: published result moves only at a scan end
    a_r5_atomic_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !scan_done_i |=> $stable(res_q));
    // R3: once tripped, the count freezes until the next charge phase
    a_r3_freeze_after_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trip_q && !charge_start_i) |=> $stable(cnt_q));
    // R3: a saturated count never wraps
    a_r3_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == '1 && !charge_start_i) |=> (cnt_q == '1));
endmodule

// File: rtl/pot_legacy_view.sv
module pot_legacy_view
    import pot_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned LEG_DIV = 50,
    parameter int unsigned LEG_WIN = 512
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             timed_en_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] live_x_i,
    input  logic [CNT_W-1:0] live_y_i,
    output logic [CNT_W-1:0] leg_x_o,
    output logic [CNT_W-1:0] leg_y_o
);
    localparam int unsigned PRE_W = (LEG_DIV > 1) ? $clog2(LEG_DIV) : 1;
    localparam int unsigned WIN_W = (LEG_WIN > 1) ? $clog2(LEG_WIN) : 1;

    leg_state_t       st_q, st_d;
    logic [PRE_W-1:0] pre_q;
    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] snap_x_q, snap_y_q;
    logic             us_tick, win_end;

    assign us_tick = (pre_q == PRE_W'(LEG_DIV - 1));
    assign win_end = (st_q == LEG_WAIT) && us_tick && (win_q == WIN_W'(LEG_WIN - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LEG_LIVE: if (timed_en_i)  st_d = LEG_WAIT;
            LEG_WAIT: if (!timed_en_i) st_d = LEG_LIVE;
            default:  st_d = LEG_LIVE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= LEG_LIVE;
        else         st_q <= st_d;
    end

    // 1 MHz prescaler and window counter, held at zero while live
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
            win_q <= '0;
        end else if (st_q == LEG_LIVE || restart_i) begin
            pre_q <= '0;
            win_q <= '0;
        end else if (us_tick) begin
            pre_q <= '0;
            win_q <= win_end ? '0 : win_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            snap_x_q <= '1;
            snap_y_q <= '1;
        end else if (st_q == LEG_LIVE || (win_end && !restart_i)) begin
            snap_x_q <= live_x_i;
            snap_y_q <= live_y_i;
        end
    end

    always_comb begin
        leg_x_o = (st_q == LEG_LIVE) ? live_x_i : snap_x_q;
        leg_y_o = (st_q == LEG_LIVE) ? live_y_i : snap_y_q;
    end

    // R8: while waiting, the snapshot moves only at a window end
    a_r8_snapshot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == LEG_WAIT && !win_end) |=> ($stable(snap_x_q) && $stable(snap_y_q)));
endmodule

// File: rtl/paddle_scan.sv
module paddle_scan
    import pot_pkg::*;
#(
    parameter int unsigned PHASE   = 256,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned LEG_DIV = 50,
    parameter int unsigned LEG_WIN = 512
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [3:0]        cmp_i,
    output logic [3:0]        dump_o
);
    localparam int unsigned LINES = 4;

    logic [DATA_W-1:0] ctrl_q;
    logic [1:0]        mode_q;
    logic [DIV_W-1:0]  div_q;
    logic              tick, charge_start, charging, scan_done, dump;
    logic [CNT_W-1:0]  res [LINES];
    logic [LINES-1:0]  pressed;
    logic              port2_sel, ctrl_wr;
    logic [CNT_W-1:0]  live_x, live_y, leg_x, leg_y;

    assign ctrl_wr = bus_wr_i && (bus_addr_i == A_CTRL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
            mode_q <= '0;
            div_q  <= '0;
        end else if (bus_wr_i) begin
            if (bus_addr_i == A_CTRL) ctrl_q <= bus_wdata_i;
            if (bus_addr_i == A_MODE) mode_q <= bus_wdata_i[1:0];
            if (bus_addr_i == A_DIV)  div_q  <= DIV_W'(bus_wdata_i);
        end
    end

    pot_scan_seq #(.PHASE(PHASE), .DIV_W(DIV_W)) seq_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .div_i          (div_q),
        .tick_o         (tick),
        .charge_start_o (charge_start),
        .charging_o     (charging),
        .scan_done_o    (scan_done),
        .dump_o         (dump)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        pot_line_meas #(.CNT_W(CNT_W)) meas_i (
            .clk_i          (clk_i),
            .rst_ni         (rst_ni),
            .tick_i         (tick),
            .charge_start_i (charge_start),
            .charging_i     (charging),
            .scan_done_i    (scan_done),
            .cmp_i          (cmp_i[g]),
            .res_o          (res[g])
        );
        assign pressed[g] = ~res[g][CNT_W-1];
        assign dump_o[g]  = dump;
    end

    assign port2_sel = (ctrl_q[7:6] == 2'b10);
    assign live_x    = port2_sel ? res[2] : res[0];
    assign live_y    = port2_sel ? res[3] : res[1];

    pot_legacy_view #(.CNT_W(CNT_W), .LEG_DIV(LEG_DIV), .LEG_WIN(LEG_WIN)) leg_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .timed_en_i (mode_q[0]),
        .restart_i  (ctrl_wr),
        .live_x_i   (live_x),
        .live_y_i   (live_y),
        .leg_x_o    (leg_x),
        .leg_y_o    (leg_y)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_CTRL:  bus_rdata_o = ctrl_q;
            A_LEG_X: bus_rdata_o = DATA_W'(leg_x);
            A_LEG_Y: bus_rdata_o = DATA_W'(leg_y);
            A_MODE:  bus_rdata_o = DATA_W'(mode_q);
            A_P1X:   bus_rdata_o = DATA_W'(res[0]);
            A_P1Y:   bus_rdata_o = DATA_W'(res[1]);
            A_P2X:   bus_rdata_o = DATA_W'(res[2]);
            A_P2Y:   bus_rdata_o = DATA_W'(res[3]);
            A_BTN:   bus_rdata_o = mode_q[1] ? DATA_W'(pressed) : '0;
            A_DIV:   bus_rdata_o = DATA_W'(div_q);
            default: bus_rdata_o = '0;
        endcase
    end

    // R9: the button register never shows bits while button mode is off
    a_r9_btn_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == A_BTN && !mode_q[1]) |-> (bus_rdata_o == '0));
endmodule

// File: tb/paddle_scan_tb_top.sv
module paddle_scan_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    wire  [7:0] rdata;
    logic [3:0] cmp = '0;
    wire  [3:0] dump;

    int checks = 0;
    int failures = 0;
    int tgt [4] = '{1000, 1000, 1000, 1000};
    int el  [4] = '{0, 0, 0, 0};

    // per vector: targets p1x,p1y,p2x,p2y ; expected p1x,p1y,p2x,p2y ; buttons ; ctrl ; legacy x ; legacy y
    localparam int NV = 3;
    localparam int VEC [NV][12] = '{
        '{10,  200, 0,   300,  10,  200, 0,   255, 5, 8'h40, 10,  200},
        '{127, 128, 255, 256,  127, 128, 255, 255, 1, 8'h80, 255, 255},
        '{1,   64,  254, 1000, 1,   64,  254, 255, 3, 8'hC0, 1,   64}
    };

    always #10 clk = ~clk;

    paddle_scan dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .cmp_i       (cmp),
        .dump_o      (dump)
    );

    // line model: comparator goes high once the line has charged past its target
    always @(negedge clk) begin
        for (int j = 0; j < 4; j++) begin
            if (dump[j]) el[j] = 0;
            else         el[j] = el[j] + 1;
            cmp[j] = (el[j] > tgt[j]);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; wr = 1'b0;
        #1;
        d = rdata;
    endtask

    task automatic wait_scan_end();
        logic prev;
        prev = dump[0];
        @(negedge clk);
        while (!(dump[0] && !prev)) begin
            prev = dump[0];
            @(negedge clk);
        end
    endtask

    task automatic measure(output int per, output int low);
        per = 0; low = 0;
        wait_scan_end();
        do begin
            @(negedge clk);
            per++;
            if (!dump[0]) low++;
        end while (!(dump[0] && per > 1 && low == per - 1 - (per - 1 - low) && dump[0] && !$isunknown(dump) && (per > 300 * 0 + 1) && is_rise()));
    endtask

    logic last_dump = 1'b1;
    always @(negedge clk) last_dump <= dump[0];
    function automatic bit is_rise();
        return dump[0] && !last_dump;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] snap [4];
        int per, low;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, well before the first scan ends
        for (int a = 4; a < 8; a++) begin
            rd_reg(4'(a), d); check("R1 dedicated reset", d, 255);
        end
        rd_reg(4'h1, d); check("R1 legacy X reset", d, 255);
        rd_reg(4'h2, d); check("R1 legacy Y reset", d, 255);
        rd_reg(4'h8, d); check("R1 button reset", d, 0);
        rd_reg(4'h3, d); check("R1 mode reset", d, 0);
        rd_reg(4'h9, d); check("R1 divider reset", d, 0);
        rd_reg(4'h0, d); check("R1 control reset", d, 0);
        check("R1 discharge high", dump, 4'hF);

        // R2 scan timing at divider 0
        measure(per, low);
        check("R2 scan period", per, 512);
        check("R2 charge length", low, 256);

        // R10 register readback
        wr_reg(4'h0, 8'h5A); rd_reg(4'h0, d); check("R10 control readback", d, 8'h5A);
        wr_reg(4'h3, 8'h02); rd_reg(4'h3, d); check("R10 mode readback", d, 2);
        rd_reg(4'hF, d); check("R10 unmapped reads zero", d, 0);

        // vector table: R3, R4, R5, R7, R9
        for (int v = 0; v < NV; v++) begin
            wr_reg(4'h0, 8'(VEC[v][9]));
            for (int j = 0; j < 4; j++) tgt[j] = VEC[v][j];
            wait_scan_end();
            for (int j = 0; j < 4; j++) rd_reg(4'(4 + j), snap[j]);
            repeat (300) @(negedge clk);
            for (int j = 0; j < 4; j++) begin
                rd_reg(4'(4 + j), d); check("R5 mid-scan value held", d, snap[j]);
            end
            wait_scan_end();
            rd_reg(4'h4, d); check("R3 R4 port1 X", d, VEC[v][4]);
            rd_reg(4'h5, d); check("R3 R4 port1 Y", d, VEC[v][5]);
            rd_reg(4'h6, d); check("R3 R4 port2 X", d, VEC[v][6]);
            rd_reg(4'h7, d); check("R3 R4 port2 Y", d, VEC[v][7]);
            rd_reg(4'h8, d); check("R9 button bits", d, VEC[v][8]);
            rd_reg(4'h1, d); check("R7 legacy X live", d, VEC[v][10]);
            rd_reg(4'h2, d); check("R7 legacy Y live", d, VEC[v][11]);
        end

        // R9 button mode off
        wr_reg(4'h3, 8'h00); rd_reg(4'h8, d); check("R9 buttons off", d, 0);

        // R7 immediate port switch in live mode
        wr_reg(4'h0, 8'h80);
        rd_reg(4'h1, d); check("R7 switch X immediate", d, 254);
        rd_reg(4'h2, d); check("R7 switch Y immediate", d, 255);

        // R6 divider
        wr_reg(4'h9, 8'd3); rd_reg(4'h9, d); check("R10 divider readback", d, 3);
        wait_scan_end();
        measure(per, low);
        check("R6 scan period div 3", per, 2048);
        wr_reg(4'h9, 8'd0);
        wait_scan_end();
        wait_scan_end();

        // R8 timed legacy view
        tgt = '{10, 20, 30, 40};
        wait_scan_end();
        wait_scan_end();
        wr_reg(4'h0, 8'h40);
        wr_reg(4'h3, 8'h01);
        repeat (4) @(negedge clk);
        rd_reg(4'h1, d); check("R8 entry snapshot X", d, 10);
        wr_reg(4'h0, 8'h80);
        repeat (25585) @(negedge clk);
        rd_reg(4'h1, d); check("R8 old X before window end", d, 10);
        rd_reg(4'h2, d); check("R8 old Y before window end", d, 20);
        repeat (19) @(negedge clk);
        rd_reg(4'h1, d); check("R8 new X after window end", d, 30);
        rd_reg(4'h2, d); check("R8 new Y after window end", d, 40);
        wr_reg(4'h0, 8'h40);
        rd_reg(4'h1, d); check("R8 restart keeps snapshot", d, 30);
        wr_reg(4'h3, 8'h00);
        rd_reg(4'h1, d); check("R7 live after timed mode", d, 10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule